// File: doc/BRIEF.md
# Character Display Instruction Executor

This block is the device side of a character display controller. A host reaches it over a byte-wide parallel bus with a register-select bit, a read/not-write bit and a one-cycle access strobe. Each access falls into one of four kinds: an instruction write, a status read, a data write, or a data read. Instructions set the address counter, the display mode flags and a display shift offset. Data accesses go to an 80-entry display memory of character codes or to a 64-byte glyph pattern memory. The target is whichever memory the most recent set-address instruction named.

Every accepted operation starts a busy window whose length depends on its kind. The lengths come from a clock-rate parameter in kHz: the long window is 1530 µs, the short one 39 µs and a data access 43 µs. A host polls the status read, which is always served, until the busy bit drops. Only then does it issue the next access. The mode flags and the shift offset go to the scan-out logic, which is outside this block.

Top module: `charlcd_exec`

## Requirements
- R1: Each strobe is routed by {reg_sel, rd_nwr}. 00 is an instruction write. 01 is a status read that returns busy in rdata_o[7] and the address counter in rdata_o[6:0] one cycle later. 10 writes wdata to the current target memory. 11 returns the target memory entry at the address counter in rdata_o one cycle later.
- R2: An instruction byte is decoded by its highest set bit. Bit 7 is set-display-address. Bit 6 is set-pattern-address. Bit 5 is mode set. Bit 4 is shift. Bit 3 is display control. Bit 2 is entry mode. Bit 1 is home (bit 0 ignored). Only bit 0 set is clear. The byte 0x00 is a no-op that starts no busy window.
- R3: For an access accepted at edge E, a status read at edge E+k reports busy=1 exactly for k = 1..N. N is 1530·CLK_KHZ/1000 for clear and home, 39·CLK_KHZ/1000 for other instructions, and 43·CLK_KHZ/1000 for data reads and writes. A status read starts no window.
- R4: While busy, instruction writes and data reads and writes are ignored. Neither memory, the address counter, mode_o, shift_o nor rdata_o changes, and the window already running is not restarted.
- R5: Clear writes 0x20 to all 80 display entries within its busy window. It also sets the address counter to 0 with display memory as the target. Home sets the counter to 0 and the target to display memory, and leaves memory contents unchanged.
- R6: Instruction 0x80|a targets display memory with counter a, and a value of 80..127 is reduced by 80. Instruction 0x40|a targets pattern memory with counter a (0..63). Pattern writes never alter display memory.
- R7: After each accepted data read or write, the counter steps +1 when mode_o[0]=1 and −1 otherwise. It wraps 79↔0 for display memory and 63↔0 for pattern memory.
- R8: Entry mode sets mode_o[0] from bit 1 and mode_o[1] from bit 0. Display control sets mode_o[4:2] from bits 2:0. Mode set sets mode_o[7:5] from bits 4:2.
- R9: For the shift instruction, bit 3 = 0 moves the counter by one (+1 when bit 2 = 1, −1 otherwise) with the R7 wrap rule. Bit 3 = 1 moves shift_o by one in the same way, wrapping 79↔0, and leaves the counter unchanged.
- R10: When mode_o[1]=1, an accepted data write to display memory also steps shift_o by one in the counter's direction, wrapping 79↔0.
- R11: After reset the counter is 0 with display memory as target. Busy is 0, mode_o is 0x81, shift_o is 0 and rdata_o is 0. Every display entry is 0x20 and every pattern byte is 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| strobe | input | 1 | One-cycle access request |
| reg_sel | input | 1 | 0 = instruction/status, 1 = data |
| rd_nwr | input | 1 | 1 = read, 0 = write |
| wdata | input | 8 | Instruction or data byte |
| rdata_o | output | 8 | Status or memory read result, registered |
| mode_o | output | 8 | Display mode flags (R8 bit map) |
| shift_o | output | 7 | Display shift offset, 0..79 |

## Verification
The assertions assume that reg_sel, rd_nwr and wdata matter only in a cycle where strobe is high, and that they are stable at that edge. They also assume every strobe lasts one cycle and stands for one access. The stimulus changes inputs only on the falling edge and pulses the strobe for a single cycle. Between operations it polls status on consecutive cycles until busy clears, so each busy window is counted edge by edge. It issues accesses during a busy window only on purpose, to show that they are dropped.

// File: rtl/charlcd_pkg.sv
package charlcd_pkg;

    localparam int DW       = 8;
    localparam int AC_W     = 7;
    localparam int DD_DEPTH = 80;
    localparam int CG_DEPTH = 64;
    localparam int CG_AW    = $clog2(CG_DEPTH);
    localparam logic [DW-1:0] BLANK_CODE = 8'h20;

    // mode flag positions
    localparam int M_INC   = 0;
    localparam int M_SHEN  = 1;
    localparam int M_BLINK = 2;
    localparam int M_FONT  = 5;
    localparam logic [DW-1:0] MODE_RST = 8'h81;

    typedef enum logic [3:0] {
        OP_NONE, OP_CLEAR, OP_HOME, OP_ENTRY, OP_DISPCTL,
        OP_SHIFT, OP_FUNC, OP_SETCG, OP_SETDD
    } op_e;

    typedef struct packed {
        op_e             op;
        logic [AC_W-1:0] arg;
    } cmd_t;

    function automatic logic [AC_W-1:0] ring_step(input logic [AC_W-1:0] a,
                                                  input logic up,
                                                  input int depth);
        if (up)
            return (int'(a) == depth - 1) ? '0 : a + 1'b1;
        else
            return (a == '0) ? AC_W'(depth - 1) : a - 1'b1;
    endfunction

    function automatic logic [AC_W-1:0] fold_dd(input logic [AC_W-1:0] a);
        return (int'(a) >= DD_DEPTH) ? a - AC_W'(DD_DEPTH) : a;
    endfunction

endpackage

// File: rtl/charlcd_decode.sv
module charlcd_decode
    import charlcd_pkg::*;
(
    input  logic [DW-1:0] code,
    output cmd_t          cmd
);
    always_comb begin
        cmd.arg = code[AC_W-1:0];
        casez (code)
            8'b1???????: cmd.op = OP_SETDD;
            8'b01??????: cmd.op = OP_SETCG;
            8'b001?????: cmd.op = OP_FUNC;
            8'b0001????: cmd.op = OP_SHIFT;
            8'b00001???: cmd.op = OP_DISPCTL;
            8'b000001??: cmd.op = OP_ENTRY;
            8'b0000001?: cmd.op = OP_HOME;
            8'b00000001: cmd.op = OP_CLEAR;
            default:     cmd.op = OP_NONE;
        endcase
    end
endmodule

// File: rtl/charlcd_busy_timer.sv
module charlcd_busy_timer #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] len,
    output logic          busy
);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= len;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign busy = (cnt != '0);

    // a new window may only open once the previous one has fully run out
    assert_load_idle_R4: assert property (@(posedge clk) disable iff (rst)
        load |-> (cnt == '0));

endmodule

// File: rtl/charlcd_ram.sv
module charlcd_ram #(
    parameter int              DEPTH     = 64,
    parameter int              WIDTH     = 8,
    parameter logic [WIDTH-1:0] RESET_VAL = '0,
    localparam int             AW        = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= RESET_VAL;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];

    assert_waddr_in_range_R6: assert property (@(posedge clk) disable iff (rst)
        we |-> (int'(waddr) < DEPTH));

endmodule

// File: rtl/charlcd_exec.sv
module charlcd_exec
    import charlcd_pkg::*;
#(
    parameter int CLK_KHZ = 10000
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            strobe,
    input  logic            reg_sel,
    input  logic            rd_nwr,
    input  logic [DW-1:0]   wdata,
    output logic [DW-1:0]   rdata_o,
    output logic [DW-1:0]   mode_o,
    output logic [AC_W-1:0] shift_o
);
    localparam int LONG_CYC  = 1530 * CLK_KHZ / 1000;
    localparam int SHORT_CYC = 39 * CLK_KHZ / 1000;
    localparam int DATA_CYC  = 43 * CLK_KHZ / 1000;
    localparam int CW        = $clog2(LONG_CYC + 1);
    localparam int DD_AW     = $clog2(DD_DEPTH);

    logic [AC_W-1:0]  ac;
    logic             tgt_dd;
    logic [DW-1:0]    mode_q;
    logic [AC_W-1:0]  shift_q;
    logic [DW-1:0]    rdata_q;
    logic             clr_active;
    logic [DD_AW-1:0] clr_ptr;

    logic             busy;
    cmd_t             cmd;
    logic             is_status, do_instr, do_data;
    logic             t_load;
    logic [CW-1:0]    t_len;
    logic [DW-1:0]    dd_rd, cg_rd, dd_wd;
    logic             dd_we, cg_we;
    logic [DD_AW-1:0] dd_wa;
    int               tgt_depth;

    charlcd_decode u_dec (.code(wdata), .cmd(cmd));

    assign is_status = strobe & ~reg_sel & rd_nwr;
    assign do_instr  = strobe & ~reg_sel & ~rd_nwr & ~busy;
    assign do_data   = strobe & reg_sel & ~busy;
    assign tgt_depth = tgt_dd ? DD_DEPTH : CG_DEPTH;

    always_comb begin
        t_load = do_data | (do_instr & (cmd.op != OP_NONE));
        if (do_data)
            t_len = CW'(DATA_CYC);
        else if (cmd.op == OP_CLEAR || cmd.op == OP_HOME)
            t_len = CW'(LONG_CYC);
        else
            t_len = CW'(SHORT_CYC);
    end

    charlcd_busy_timer #(.CW(CW)) u_busy (
        .clk(clk), .rst(rst), .load(t_load), .len(t_len), .busy(busy)
    );

    // display memory: clear sweep has the write port while it runs
    assign dd_we = clr_active | (do_data & ~rd_nwr & tgt_dd);
    assign dd_wa = clr_active ? clr_ptr : DD_AW'(ac);
    assign dd_wd = clr_active ? BLANK_CODE : wdata;
    assign cg_we = do_data & ~rd_nwr & ~tgt_dd;

    charlcd_ram #(.DEPTH(DD_DEPTH), .WIDTH(DW), .RESET_VAL(BLANK_CODE)) u_dd (
        .clk(clk), .rst(rst), .we(dd_we), .waddr(dd_wa), .wdata(dd_wd),
        .raddr(DD_AW'(ac)), .rdata(dd_rd)
    );

    charlcd_ram #(.DEPTH(CG_DEPTH), .WIDTH(DW), .RESET_VAL('0)) u_cg (
        .clk(clk), .rst(rst), .we(cg_we), .waddr(ac[CG_AW-1:0]), .wdata(wdata),
        .raddr(ac[CG_AW-1:0]), .rdata(cg_rd)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ac         <= '0;
            tgt_dd     <= 1'b1;
            mode_q     <= MODE_RST;
            shift_q    <= '0;
            rdata_q    <= '0;
            clr_active <= 1'b0;
            clr_ptr    <= '0;
        end else begin
            if (clr_active) begin
                clr_ptr <= clr_ptr + 1'b1;
                if (int'(clr_ptr) == DD_DEPTH - 1) clr_active <= 1'b0;
            end

            if (is_status) rdata_q <= {busy, ac};

            if (do_instr) begin
                case (cmd.op)
                    OP_CLEAR: begin
                        ac         <= '0;
                        tgt_dd     <= 1'b1;
                        clr_active <= 1'b1;
                        clr_ptr    <= '0;
                    end
                    OP_HOME: begin
                        ac     <= '0;
                        tgt_dd <= 1'b1;
                    end
                    OP_ENTRY: begin
                        mode_q[M_INC]  <= wdata[1];
                        mode_q[M_SHEN] <= wdata[0];
                    end
                    OP_DISPCTL: mode_q[M_BLINK+:3] <= wdata[2:0];
                    OP_FUNC:    mode_q[M_FONT+:3]  <= wdata[4:2];
                    OP_SHIFT: begin
                        if (wdata[3])
                            shift_q <= ring_step(shift_q, wdata[2], DD_DEPTH);
                        else
                            ac <= ring_step(ac, wdata[2], tgt_depth);
                    end
                    OP_SETCG: begin
                        ac     <= {1'b0, cmd.arg[CG_AW-1:0]};
                        tgt_dd <= 1'b0;
                    end
                    OP_SETDD: begin
                        ac     <= fold_dd(cmd.arg);
                        tgt_dd <= 1'b1;
                    end
                    default: ;
                endcase
            end

            if (do_data) begin
                if (rd_nwr) rdata_q <= tgt_dd ? dd_rd : cg_rd;
                ac <= ring_step(ac, mode_q[M_INC], tgt_depth);
                if (!rd_nwr && tgt_dd && mode_q[M_SHEN])
                    shift_q <= ring_step(shift_q, mode_q[M_INC], DD_DEPTH);
            end
        end
    end

    assign rdata_o = rdata_q;
    assign mode_o  = mode_q;
    assign shift_o = shift_q;

    assert_busy_ignores_R4: assert property (@(posedge clk) disable iff (rst)
        (strobe && !is_status && busy) |=>
            ($stable(ac) && $stable(mode_q) && $stable(shift_q) && $stable(rdata_q)));

    assert_window_opens_R3: assert property (@(posedge clk) disable iff (rst)
        (do_instr && cmd.op != OP_NONE) |=> busy);

    assert_status_counter_R1: assert property (@(posedge clk) disable iff (rst)
        is_status |=> (rdata_o[AC_W-1:0] == $past(ac)));

    assert_dd_counter_range_R7: assert property (@(posedge clk) disable iff (rst)
        tgt_dd |-> (int'(ac) < DD_DEPTH));

    assert_clear_inside_window_R5: assert property (@(posedge clk) disable iff (rst)
        clr_active |-> busy);

    assert_shift_range_R9: assert property (@(posedge clk) disable iff (rst)
        int'(shift_q) < DD_DEPTH);

endmodule

// File: tb/charlcd_exec_tb.sv
module charlcd_exec_tb;
    localparam int KHZ   = 2000;
    localparam int LONG  = 1530 * KHZ / 1000;
    localparam int SHORT = 39 * KHZ / 1000;
    localparam int DATA  = 43 * KHZ / 1000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       strobe = 1'b0, reg_sel = 1'b0, rd_nwr = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata_o, mode_o;
    logic [6:0] shift_o;

    int checks = 0, errors = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];
    logic trk = 1'b0, trk_q = 1'b0;

    always #2 clk = ~clk;

    charlcd_exec #(.CLK_KHZ(KHZ)) u_dut (
        .clk(clk), .rst(rst), .strobe(strobe), .reg_sel(reg_sel), .rd_nwr(rd_nwr),
        .wdata(wdata), .rdata_o(rdata_o), .mode_o(mode_o), .shift_o(shift_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // scoreboard monitor: compares every tracked read one cycle after its strobe
    always @(posedge clk) trk_q <= strobe & trk;
    always @(negedge clk) begin
        if (trk_q) begin
            if (exp_q.size() == 0) begin
                check(0, "scoreboard underflow", rdata_o, 0);
            end else begin
                logic [7:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(rdata_o == e, t, rdata_o, e);
            end
        end
    end

    task automatic access(input logic rs, input logic rw, input logic [7:0] d, input logic tr);
        reg_sel = rs; rd_nwr = rw; wdata = d; trk = tr; strobe = 1'b1;
        @(negedge clk);
        strobe = 1'b0; trk = 1'b0;
    endtask

    task automatic instr(input logic [7:0] b);  access(1'b0, 1'b0, b, 1'b0); endtask
    task automatic wdat(input logic [7:0] b);   access(1'b1, 1'b0, b, 1'b0); endtask

    task automatic rd_expect(input logic rs, input logic [7:0] e, input string t);
        exp_q.push_back(e);
        tag_q.push_back(t);
        access(rs, 1'b1, 8'h00, 1'b1);
    endtask

    task automatic busy_len(output int n);
        n = 0;
        forever begin
            access(1'b0, 1'b1, 8'h00, 1'b0);
            if (!rdata_o[7] || n > 100000) break;
            n++;
        end
    endtask

    task automatic settle();
        int n;
        busy_len(n);
    endtask

    task automatic measure(input string req, input int exp);
        int n;
        busy_len(n);
        check(n == exp, req, n, exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R11 reset state
        check(mode_o == 8'h81, "R11 mode after reset", mode_o, 8'h81);
        check(shift_o == 0, "R11 shift after reset", shift_o, 0);
        check(rdata_o == 0, "R11 rdata after reset", rdata_o, 0);
        rd_expect(0, 8'h00, "R1 R11 status after reset");
        rd_expect(1, 8'h20, "R11 display blank after reset");
        measure("R3 data read window", DATA);
        rd_expect(0, 8'h01, "R7 counter up after read");

        // R1 write/read routing
        instr(8'h85);
        measure("R3 short instruction window", SHORT);
        wdat(8'h41); settle();
        wdat(8'h42); settle();
        rd_expect(0, 8'h07, "R7 counter after two writes");
        instr(8'h85); settle();
        rd_expect(1, 8'h41, "R1 read back entry 5"); settle();
        rd_expect(1, 8'h42, "R1 read back entry 6"); settle();

        // R4 accesses during busy are dropped
        instr(8'h85);
        wdat(8'h55);
        instr(8'h04);
        check(mode_o == 8'h81, "R4 mode unchanged while busy", mode_o, 8'h81);
        measure("R4 window not restarted", SHORT - 2);
        rd_expect(0, 8'h05, "R4 counter unchanged by dropped write");
        rd_expect(1, 8'h41, "R4 entry unchanged by dropped write"); settle();

        // R2 no-op
        instr(8'h00);
        measure("R2 zero byte opens no window", 0);
        rd_expect(0, 8'h06, "R2 counter unchanged by no-op");

        // R7 R8 decrement and wrap down
        instr(8'h04); settle();
        check(mode_o == 8'h80, "R8 entry mode decrement", mode_o, 8'h80);
        instr(8'h80); settle();
        wdat(8'h33); settle();
        rd_expect(0, 8'h4F, "R7 wrap 0 to 79");
        rd_expect(1, 8'h20, "R7 read entry 79"); settle();
        rd_expect(0, 8'h4E, "R7 decrement after read");

        // R7 wrap up
        instr(8'h06); settle();
        check(mode_o == 8'h81, "R8 entry mode increment", mode_o, 8'h81);
        instr(8'hCF); settle();
        wdat(8'h77); settle();
        rd_expect(0, 8'h00, "R7 wrap 79 to 0");
        rd_expect(1, 8'h33, "R7 entry 0 holds decrement write"); settle();

        // R6 address folding and pattern memory
        instr(8'hD5); settle();
        rd_expect(0, 8'h05, "R6 address 85 folds to 5");
        instr(8'h7F); settle();
        wdat(8'h1F); settle();
        rd_expect(0, 8'h00, "R7 pattern wrap 63 to 0");
        instr(8'h7F); settle();
        rd_expect(1, 8'h1F, "R6 pattern read back"); settle();
        rd_expect(0, 8'h00, "R7 pattern counter after read");
        instr(8'h42); settle();
        rd_expect(1, 8'h00, "R11 pattern reset value"); settle();
        instr(8'hBF); settle();
        rd_expect(1, 8'h20, "R6 display untouched by pattern write"); settle();

        // R5 home
        instr(8'h82); settle();
        wdat(8'h99); settle();
        instr(8'h03);
        measure("R3 home window", LONG);
        rd_expect(0, 8'h00, "R5 home resets counter");
        instr(8'h82); settle();
        rd_expect(1, 8'h99, "R5 home keeps contents"); settle();

        // R5 clear
        instr(8'h01);
        measure("R3 clear window", LONG);
        rd_expect(0, 8'h00, "R5 clear resets counter");
        rd_expect(1, 8'h20, "R5 clear blanks entry 0"); settle();
        instr(8'h82); settle();
        rd_expect(1, 8'h20, "R5 clear blanks entry 2"); settle();
        instr(8'hCF); settle();
        rd_expect(1, 8'h20, "R5 clear blanks entry 79"); settle();

        // R8 flags
        instr(8'h0F);
        measure("R3 display control window", SHORT);
        check(mode_o == 8'h9D, "R8 display control bits", mode_o, 8'h9D);
        instr(8'h3C); settle();
        check(mode_o == 8'hFD, "R8 mode set all ones", mode_o, 8'hFD);
        instr(8'h20); settle();
        check(mode_o == 8'h1D, "R8 mode set all zeros", mode_o, 8'h1D);

        // R9 shift instruction
        instr(8'h83); settle();
        instr(8'h14); settle();
        rd_expect(0, 8'h04, "R9 cursor right");
        instr(8'h10); settle();
        instr(8'h10); settle();
        rd_expect(0, 8'h02, "R9 cursor left twice");
        instr(8'h18); settle();
        check(shift_o == 7'd79, "R9 display shift left wraps", shift_o, 79);
        rd_expect(0, 8'h02, "R9 display shift keeps counter");
        instr(8'h1C); settle();
        check(shift_o == 7'd0, "R9 display shift right wraps", shift_o, 0);

        // R10 shift on write
        instr(8'h07); settle();
        check(mode_o == 8'h1F, "R8 entry with shift enable", mode_o, 8'h1F);
        wdat(8'h11); settle();
        check(shift_o == 7'd1, "R10 write shifts display up", shift_o, 1);
        rd_expect(0, 8'h03, "R10 counter steps with shift");
        instr(8'h05); settle();
        wdat(8'h12); settle();
        check(shift_o == 7'd0, "R10 write shifts display down", shift_o, 0);
        rd_expect(0, 8'h02, "R10 counter steps down");

        @(negedge clk);
        check(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule